// File: doc/BRIEF.md
# Two-Port Read Switch with ID Prefix Routing

This block joins two read initiators to a single read target on a burst bus that carries transaction IDs. Requests on the two read-address ports compete for the one target address port. An arbiter picks the winner and alternates between the ports when both ask at the same time. Before a request reaches the target, the index of the winning port is placed above its ID. The target-side ID is therefore one bit wider than the initiator-side ID.

Read-data beats from the target find their way back using only that top ID bit. The block keeps no lookup table and no ordering queue. The beat goes to the port that the bit names, and the bit is removed, so each initiator sees the ID it issued. Once a burst has started, its remaining beats stay with the same port until the beat that carries the last flag. Ordering among beats with the same ID is left to the target. Each channel moves a beat only in a cycle where both valid and ready are high.

Top module: `idpfx_rd_switch`

## Requirements
- R1: An accepted target request carries `t_arid = {port, id}`, where port is 0 for initiator 0 and 1 for initiator 1 and sits in bit ID_W. Its address and length are those of the granted initiator.
- R2: At most one initiator sees address ready high. It is the granted one, and its ready equals `t_arready`.
- R3: When both initiators request and no grant is held, the port opposite the last accepted winner wins. After reset, port 0 wins.
- R4: While `t_arvalid` is high and `t_arready` is low, the grant does not move. The target sees the same ID, address and length in the next cycle.
- R5: Outside a burst, a read beat goes to the port named by `t_rid[ID_W]`. The other port's `rvalid` stays low.
- R6: The delivered `rid` is `t_rid[ID_W-1:0]`. Data, response and the last flag pass through unchanged.
- R7: `t_rready` equals the `rready` of the port that the current beat is routed to.
- R8: After a non-last beat is accepted, the following beats route to the same port until a last beat is accepted.
- R9: While reset is active, `t_arvalid`, both address readies and both `rvalid` outputs are low when their inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i0_arvalid | input | 1 | Initiator 0 request valid |
| i0_arready | output | 1 | Initiator 0 request ready |
| i0_arid | input | ID_W | Initiator 0 request ID |
| i0_araddr | input | ADDR_W | Initiator 0 start address |
| i0_arlen | input | LEN_W | Initiator 0 burst length |
| i0_rvalid | output | 1 | Beat valid to initiator 0 |
| i0_rready | input | 1 | Initiator 0 beat ready |
| i0_rid | output | ID_W | Stripped ID to initiator 0 |
| i0_rdata | output | DATA_W | Beat data to initiator 0 |
| i0_rresp | output | RESP_W | Beat status to initiator 0 |
| i0_rlast | output | 1 | Last-beat flag to initiator 0 |
| i1_arvalid | input | 1 | Initiator 1 request valid |
| i1_arready | output | 1 | Initiator 1 request ready |
| i1_arid | input | ID_W | Initiator 1 request ID |
| i1_araddr | input | ADDR_W | Initiator 1 start address |
| i1_arlen | input | LEN_W | Initiator 1 burst length |
| i1_rvalid | output | 1 | Beat valid to initiator 1 |
| i1_rready | input | 1 | Initiator 1 beat ready |
| i1_rid | output | ID_W | Stripped ID to initiator 1 |
| i1_rdata | output | DATA_W | Beat data to initiator 1 |
| i1_rresp | output | RESP_W | Beat status to initiator 1 |
| i1_rlast | output | 1 | Last-beat flag to initiator 1 |
| t_arvalid | output | 1 | Request valid to target |
| t_arready | input | 1 | Target request ready |
| t_arid | output | ID_W+1 | Widened request ID |
| t_araddr | output | ADDR_W | Request address to target |
| t_arlen | output | LEN_W | Burst length to target |
| t_rvalid | input | 1 | Target beat valid |
| t_rready | output | 1 | Beat ready to target |
| t_rid | input | ID_W+1 | Widened beat ID from target |
| t_rdata | input | DATA_W | Target beat data |
| t_rresp | input | RESP_W | Target beat status |
| t_rlast | input | 1 | Target last-beat flag |

## Verification
A wrong priority bit or a stale hold flag shows up when both ports next compete in the same cycle. The target then sees the wrong prefix on `t_arid` with no delay, and the wrong initiator gets `arready`. A lock register that clears too early or too late sends the second beat of a burst to the wrong initiator in the very cycle that beat is presented. The bench models the grant and lock state from the requirements and compares every port on every cycle. A fault is therefore reported in the first cycle it reaches the outputs.

// File: rtl/rdsw_pkg.sv
package rdsw_pkg;
  localparam int unsigned NPORT  = 2;
  localparam int unsigned PIDX_W = 1;
  typedef logic [PIDX_W-1:0] port_idx_t;
endpackage

// File: rtl/rdsw_arb.sv
module rdsw_arb
  import rdsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req_i,
  input  logic             accept_i,
  output port_idx_t        gnt_o,
  output logic             busy_o
);
  logic      hold_q, hold_d;
  port_idx_t hidx_q, hidx_d;
  port_idx_t prio_q, prio_d;
  logic      prio_en;

  always_comb begin
    busy_o = |req_i;
    if (hold_q)
      gnt_o = hidx_q;
    else if (&req_i)
      gnt_o = prio_q;
    else
      gnt_o = port_idx_t'(req_i[1]);
  end

  always_comb begin
    hold_d  = busy_o & ~accept_i;
    hidx_d  = gnt_o;
    prio_en = busy_o & accept_i;
    prio_d  = ~gnt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      hidx_q <= '0;
      prio_q <= '0;
    end else begin
      hold_q <= hold_d;
      hidx_q <= hidx_d;
      if (prio_en) prio_q <= prio_d;
    end
  end
endmodule

// File: rtl/rdsw_ar_mux.sv
module rdsw_ar_mux
  import rdsw_pkg::*;
#(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8,
  localparam int unsigned TID_W = ID_W + PIDX_W
) (
  input  port_idx_t                     gnt_i,
  input  logic                          busy_i,
  input  logic [NPORT-1:0][ID_W-1:0]    id_i,
  input  logic [NPORT-1:0][ADDR_W-1:0]  addr_i,
  input  logic [NPORT-1:0][LEN_W-1:0]   len_i,
  input  logic                          tgt_ready_i,
  output logic [TID_W-1:0]              arid_o,
  output logic [ADDR_W-1:0]             araddr_o,
  output logic [LEN_W-1:0]              arlen_o,
  output logic [NPORT-1:0]              ready_o
);
  always_comb begin
    arid_o   = {gnt_i, id_i[gnt_i]};
    araddr_o = addr_i[gnt_i];
    arlen_o  = len_i[gnt_i];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rdy
    assign ready_o[p] = tgt_ready_i & busy_i & (gnt_i == port_idx_t'(p));
  end
endmodule

// File: rtl/rdsw_r_route.sv
module rdsw_r_route
  import rdsw_pkg::*;
#(
  parameter int unsigned ID_W = 4,
  localparam int unsigned TID_W = ID_W + PIDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rvalid_i,
  input  logic [TID_W-1:0] rid_i,
  input  logic             rlast_i,
  input  logic [NPORT-1:0] rready_i,
  output logic [NPORT-1:0] rvalid_o,
  output logic [ID_W-1:0]  rid_o,
  output logic             rready_o
);
  logic      lock_q, lock_d;
  port_idx_t lidx_q, lidx_d;
  port_idx_t sel;
  logic      beat_hs;

  always_comb begin
    sel      = lock_q ? lidx_q : rid_i[TID_W-1 -: PIDX_W];
    rid_o    = rid_i[ID_W-1:0];
    rready_o = rready_i[sel];
    beat_hs  = rvalid_i & rready_o;
    lock_d   = beat_hs ? ~rlast_i : lock_q;
    lidx_d   = beat_hs ? sel : lidx_q;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_vld
    assign rvalid_o[p] = rvalid_i & (sel == port_idx_t'(p));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      lidx_q <= '0;
    end else begin
      lock_q <= lock_d;
      lidx_q <= lidx_d;
    end
  end
endmodule

// File: rtl/idpfx_rd_switch.sv
module idpfx_rd_switch
  import rdsw_pkg::*;
#(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RESP_W = 2,
  localparam int unsigned TID_W = ID_W + PIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i0_arvalid,
  output logic              i0_arready,
  input  logic [ID_W-1:0]   i0_arid,
  input  logic [ADDR_W-1:0] i0_araddr,
  input  logic [LEN_W-1:0]  i0_arlen,
  output logic              i0_rvalid,
  input  logic              i0_rready,
  output logic [ID_W-1:0]   i0_rid,
  output logic [DATA_W-1:0] i0_rdata,
  output logic [RESP_W-1:0] i0_rresp,
  output logic              i0_rlast,
  input  logic              i1_arvalid,
  output logic              i1_arready,
  input  logic [ID_W-1:0]   i1_arid,
  input  logic [ADDR_W-1:0] i1_araddr,
  input  logic [LEN_W-1:0]  i1_arlen,
  output logic              i1_rvalid,
  input  logic              i1_rready,
  output logic [ID_W-1:0]   i1_rid,
  output logic [DATA_W-1:0] i1_rdata,
  output logic [RESP_W-1:0] i1_rresp,
  output logic              i1_rlast,
  output logic              t_arvalid,
  input  logic              t_arready,
  output logic [TID_W-1:0]  t_arid,
  output logic [ADDR_W-1:0] t_araddr,
  output logic [LEN_W-1:0]  t_arlen,
  input  logic              t_rvalid,
  output logic              t_rready,
  input  logic [TID_W-1:0]  t_rid,
  input  logic [DATA_W-1:0] t_rdata,
  input  logic [RESP_W-1:0] t_rresp,
  input  logic              t_rlast
);
  logic [NPORT-1:0]             req;
  logic [NPORT-1:0][ID_W-1:0]   ids;
  logic [NPORT-1:0][ADDR_W-1:0] addrs;
  logic [NPORT-1:0][LEN_W-1:0]  lens;
  logic [NPORT-1:0]             ardy;
  logic [NPORT-1:0]             rrdy;
  logic [NPORT-1:0]             rvld;
  logic [ID_W-1:0]              rid_strip;
  port_idx_t                    gnt;

  assign req   = {i1_arvalid, i0_arvalid};
  assign ids   = {i1_arid, i0_arid};
  assign addrs = {i1_araddr, i0_araddr};
  assign lens  = {i1_arlen, i0_arlen};
  assign rrdy  = {i1_rready, i0_rready};

  rdsw_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req),
    .accept_i (t_arready),
    .gnt_o    (gnt),
    .busy_o   (t_arvalid)
  );

  rdsw_ar_mux #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_mux (
    .gnt_i       (gnt),
    .busy_i      (t_arvalid),
    .id_i        (ids),
    .addr_i      (addrs),
    .len_i       (lens),
    .tgt_ready_i (t_arready),
    .arid_o      (t_arid),
    .araddr_o    (t_araddr),
    .arlen_o     (t_arlen),
    .ready_o     (ardy)
  );

  rdsw_r_route #(.ID_W(ID_W)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .rvalid_i (t_rvalid),
    .rid_i    (t_rid),
    .rlast_i  (t_rlast),
    .rready_i (rrdy),
    .rvalid_o (rvld),
    .rid_o    (rid_strip),
    .rready_o (t_rready)
  );

  assign i0_arready = ardy[0];
  assign i1_arready = ardy[1];
  assign i0_rvalid  = rvld[0];
  assign i1_rvalid  = rvld[1];
  assign i0_rid     = rid_strip;
  assign i1_rid     = rid_strip;
  assign i0_rdata   = t_rdata;
  assign i1_rdata   = t_rdata;
  assign i0_rresp   = t_rresp;
  assign i1_rresp   = t_rresp;
  assign i0_rlast   = t_rlast;
  assign i1_rlast   = t_rlast;
endmodule

// File: rtl/rdsw_chk.sv
module rdsw_chk #(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              i0_arvalid,
  input logic              i1_arvalid,
  input logic              i0_arready,
  input logic              i1_arready,
  input logic              t_arvalid,
  input logic              t_arready,
  input logic [ID_W:0]     t_arid,
  input logic [ADDR_W-1:0] t_araddr,
  input logic [LEN_W-1:0]  t_arlen,
  input logic              i0_rvalid,
  input logic              i1_rvalid,
  input logic              t_rvalid,
  input logic              t_rready,
  input logic              t_rlast
);
  AST_ARDY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(i0_arready && i1_arready)); // R2
  AST_PREFIX_P1: assert property (@(posedge clk) disable iff (!rst_n)
    i1_arready |-> (t_arid[ID_W] == 1'b1) && i1_arvalid); // R1
  AST_PREFIX_P0: assert property (@(posedge clk) disable iff (!rst_n)
    i0_arready |-> (t_arid[ID_W] == 1'b0) && i0_arvalid); // R1
  AST_AR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (t_arvalid && !t_arready) |=> t_arvalid && $stable(t_arid) && $stable(t_araddr) && $stable(t_arlen)); // R4
  AST_RVLD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({i1_rvalid, i0_rvalid}) && ((i0_rvalid || i1_rvalid) == t_rvalid)); // R5
  AST_BURST_P0: assert property (@(posedge clk) disable iff (!rst_n)
    (i0_rvalid && t_rready && !t_rlast) |=> !i1_rvalid); // R8
  AST_BURST_P1: assert property (@(posedge clk) disable iff (!rst_n)
    (i1_rvalid && t_rready && !t_rlast) |=> !i0_rvalid); // R8
endmodule

bind idpfx_rd_switch rdsw_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .i0_arvalid (i0_arvalid),
  .i1_arvalid (i1_arvalid),
  .i0_arready (i0_arready),
  .i1_arready (i1_arready),
  .t_arvalid  (t_arvalid),
  .t_arready  (t_arready),
  .t_arid     (t_arid),
  .t_araddr   (t_araddr),
  .t_arlen    (t_arlen),
  .i0_rvalid  (i0_rvalid),
  .i1_rvalid  (i1_rvalid),
  .t_rvalid   (t_rvalid),
  .t_rready   (t_rready),
  .t_rlast    (t_rlast)
);

// File: tb/idpfx_rd_switch_tb.sv
module idpfx_rd_switch_tb;
  localparam int ID_W = 4, ADDR_W = 32, LEN_W = 8, DATA_W = 32, RESP_W = 2;
  localparam int TID_W = ID_W + 1;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              i0_arvalid = 0, i1_arvalid = 0, i0_rready = 0, i1_rready = 0;
  logic [ID_W-1:0]   i0_arid = 0, i1_arid = 0;
  logic [ADDR_W-1:0] i0_araddr = 0, i1_araddr = 0;
  logic [LEN_W-1:0]  i0_arlen = 0, i1_arlen = 0;
  logic              t_arready = 0, t_rvalid = 0, t_rlast = 0;
  logic [TID_W-1:0]  t_rid = 0;
  logic [DATA_W-1:0] t_rdata = 0;
  logic [RESP_W-1:0] t_rresp = 0;
  logic              i0_arready, i1_arready, i0_rvalid, i1_rvalid, i0_rlast, i1_rlast;
  logic [ID_W-1:0]   i0_rid, i1_rid;
  logic [DATA_W-1:0] i0_rdata, i1_rdata;
  logic [RESP_W-1:0] i0_rresp, i1_rresp;
  logic              t_arvalid, t_rready;
  logic [TID_W-1:0]  t_arid;
  logic [ADDR_W-1:0] t_araddr;
  logic [LEN_W-1:0]  t_arlen;

  idpfx_rd_switch u_dut (.*);

  int n_run = 0, n_fail = 0;
  // model state, from the requirements
  bit m_hold = 0, m_hidx = 0, m_prio = 0, m_lock = 0, m_lidx = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_gnt(bit v0, bit v1);
    if (m_hold) return m_hidx;
    if (v0 && v1) return m_prio;
    return v1;
  endfunction

  task automatic check_cycle();
    bit g, any, sel;
    bit [1:0] rv;
    logic [ID_W-1:0] eid;
    logic [ADDR_W-1:0] ead;
    logic [LEN_W-1:0] eln;
    any = i0_arvalid | i1_arvalid;
    g   = exp_gnt(i0_arvalid, i1_arvalid);
    chk("R2 arvalid", t_arvalid, any);
    chk("R2 ready0", i0_arready, any && t_arready && !g);
    chk("R2 ready1", i1_arready, any && t_arready && g);
    if (any) begin
      eid = g ? i1_arid : i0_arid;
      ead = g ? i1_araddr : i0_araddr;
      eln = g ? i1_arlen : i0_arlen;
      chk(m_hold ? "R4 held id" : (i0_arvalid && i1_arvalid ? "R3 rr id" : "R1 id"),
          t_arid, {g, eid});
      chk("R1 addr", t_araddr, ead);
      chk("R1 len", t_arlen, eln);
    end
    sel = m_lock ? m_lidx : t_rid[ID_W];
    rv  = t_rvalid ? (sel ? 2'b10 : 2'b01) : 2'b00;
    chk(m_lock ? "R8 rvalid" : "R5 rvalid", {i1_rvalid, i0_rvalid}, rv);
    chk("R7 rready", t_rready, sel ? i1_rready : i0_rready);
    if (t_rvalid) begin
      chk("R6 rid", sel ? i1_rid : i0_rid, t_rid[ID_W-1:0]);
      chk("R6 data", sel ? i1_rdata : i0_rdata, t_rdata);
      chk("R6 resp/last", sel ? {i1_rresp, i1_rlast} : {i0_rresp, i0_rlast}, {t_rresp, t_rlast});
    end
    // advance model
    if (any && t_arready) m_prio = !g;
    m_hold = any && !t_arready;
    m_hidx = g;
    if (t_rvalid && (sel ? i1_rready : i0_rready)) begin
      m_lock = !t_rlast;
      m_lidx = sel;
    end
  endtask

  // stimulus state
  bit burst = 0, bpfx = 0;
  int pct_ar = 40, pct_tr = 50;

  task automatic drive(input bit hs0, input bit hs1, input bit rhs);
    if (!i0_arvalid || hs0) begin
      i0_arvalid = ($urandom % 100) < pct_ar;
      i0_arid = ID_W'($urandom); i0_araddr = $urandom; i0_arlen = LEN_W'($urandom);
    end
    if (!i1_arvalid || hs1) begin
      i1_arvalid = ($urandom % 100) < pct_ar;
      i1_arid = ID_W'($urandom); i1_araddr = $urandom; i1_arlen = LEN_W'($urandom);
    end
    t_arready = ($urandom % 100) < pct_tr;
    i0_rready = ($urandom % 100) < 60;
    i1_rready = ($urandom % 100) < 60;
    if (!t_rvalid || rhs) begin
      t_rvalid = ($urandom % 100) < 55;
      t_rid    = TID_W'($urandom);
      if (burst) t_rid[ID_W] = bpfx;
      t_rdata  = $urandom;
      t_rresp  = RESP_W'($urandom);
      t_rlast  = ($urandom % 4) == 0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit hs0, hs1, rhs;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R9: reset state with idle inputs
    chk("R9 t_arvalid", t_arvalid, 0);
    chk("R9 ardy", {i1_arready, i0_arready}, 0);
    chk("R9 rvalid", {i1_rvalid, i0_rvalid}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // directed R3: both request, target stalls, then accepts: port 0 first, then port 1
    i0_arvalid = 1; i0_arid = 4'h3; i0_araddr = 32'h100; i0_arlen = 8'd3;
    i1_arvalid = 1; i1_arid = 4'h5; i1_araddr = 32'h200; i1_arlen = 8'd1;
    t_arready = 0;
    @(negedge clk); chk("R3 first winner is port 0", t_arid, 5'h03); check_cycle();
    @(posedge clk); #1;
    @(negedge clk); chk("R4 grant held during stall", t_arid, 5'h03); check_cycle();
    @(posedge clk); #1; t_arready = 1;
    @(negedge clk); check_cycle();
    @(posedge clk); #1; i0_arvalid = 0;
    @(negedge clk); chk("R3 port 1 next", t_arid, 5'h15); check_cycle();
    @(posedge clk); #1; i1_arvalid = 0; t_arready = 0;
    // directed R8: non-last beat for port 1, then a beat whose prefix says port 0
    t_rvalid = 1; t_rid = 5'h12; t_rlast = 0; i0_rready = 1; i1_rready = 1;
    @(negedge clk); check_cycle();
    @(posedge clk); #1; t_rid = 5'h02; t_rlast = 1;
    @(negedge clk); chk("R8 locked to port 1", {i1_rvalid, i0_rvalid}, 2'b10); check_cycle();
    @(posedge clk); #1; t_rvalid = 0;
    @(negedge clk); check_cycle();
    // random phase
    for (int c = 0; c < NCYC; c++) begin
      if (c == NCYC / 2) begin pct_ar = 90; pct_tr = 30; end
      @(posedge clk); #1;
      drive(hs0, hs1, rhs);
      @(negedge clk);
      hs0 = i0_arvalid && !exp_gnt(i0_arvalid, i1_arvalid) && t_arready;
      hs1 = i1_arvalid && exp_gnt(i0_arvalid, i1_arvalid) && t_arready;
      begin
        bit s;
        s   = m_lock ? m_lidx : t_rid[ID_W];
        rhs = t_rvalid && (s ? i1_rready : i0_rready);
        if (rhs) begin burst = !t_rlast; bpfx = s; end
      end
      check_cycle();
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule